// File: doc/BRIEF.md
# Lockable Four-Way Tree Pseudo-LRU Selector

This block holds the replacement state of a four-way set-associative cache: three tree bits per set. It updates them on every reference, and it names the way to evict on a fill. A per-way lock mask keeps chosen ways out of replacement. Locking changes only how the stored bits are read. It never changes how they are written.

The surrounding cache controller drives the set index and, on each reference, raises the access strobe. With the strobe it gives whether the reference hit, which way hit, and whether the reference is an invalidation. The victim way, its valid flag and the addressed set's tree bits are combinational from the stored state of the set currently on `set_idx`. Updates are written on the clock edge at which the strobe is high. Tags, data arrays, coherence and the fill path live elsewhere.

Top module: `lru4_lock_sel`

## Requirements
- R1: A synchronous active-high reset clears the tree bits of every set to 000, so the first victim of each set with no locks is way 0.
- R2: The tree bits appear on `lru_bits` as {b0,b1,b2}. b0=0 selects the pair of ways 0/1 and b0=1 the pair 2/3. Within the first pair b1=0 gives way 0 and b1=1 gives way 1. Within the second pair b2=0 gives way 2 and b2=1 gives way 3. With no locks, the victim is the way these bits point at, with `victim_way` as a binary way number.
- R3: A strobed miss (`acc_hit`=0) with at least one unlocked way inverts b0 and the bit of the pair b0 pointed at. The other pair's bit is unchanged, so 00x→11x, 01x→10x, 1x0→0x1 and 1x1→0x0.
- R4: A strobed hit with `acc_inv`=0 to way w sets b0 to the opposite pair of w and points that pair's bit at w's sibling: way0→11-, way1→10-, way2→0-1, way3→0-0. The other pair's bit is kept.
- R5: A strobed hit with `acc_inv`=1 to way w makes w the tree's choice: way0→00-, way1→01-, way2→1-0, way3→1-1. The other pair's bit is kept.
- R6: The lock mask has no effect on the updates of R3 to R5, apart from the all-locked miss case of R9.
- R7: A locked way (`lock_mask[i]`=1 locks way i) is never the victim. If one way of the pair b0 selects is locked, its sibling is taken. If both are locked, the other pair is used with that pair's own bit and the same sibling rule.
- R8: With exactly three ways locked, the unlocked way is the victim. With all four locked, `victim_ok` is 0 and `victim_way` reads 0. Otherwise `victim_ok` is 1.
- R9: A strobed miss with all four ways locked leaves the set's tree bits unchanged.
- R10: With the strobe low nothing is written. An access to one set leaves every other set's bits unchanged.
- R11: `lru_bits`, `victim_way` and `victim_ok` follow the set on `set_idx` in the same cycle. A write becomes visible in the cycle after its strobed edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | SET_W | Addressed set |
| acc_en | input | 1 | Reference strobe, state written on this edge |
| acc_hit | input | 1 | Reference hit (1) or miss (0) |
| hit_way | input | 2 | Way that hit |
| acc_inv | input | 1 | Hit is an invalidation |
| lock_mask | input | 4 | Bit i excludes way i from replacement |
| victim_way | output | 2 | Way chosen for replacement |
| victim_ok | output | 1 | A replaceable way exists |
| lru_bits | output | 3 | Tree bits {b0,b1,b2} of the addressed set |

## Verification
Every cycle, the assertions check that the victim is never a locked way and that all-locked drops the valid flag. They also check, for the next cycle on the same set, the direction of each update: a hit points away from its way, an invalidation points at it, a miss flips b0, and an idle or all-locked miss holds the state. The exact bit values of the update tables, isolation between sets, the reset contents of every set, and the fallback to the other pair all depend on sequences of references. Only the bench's reference model, compared on every cycle over directed and random traffic, shows them.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  typedef logic [1:0] way_t;

  // b0 picks the pair, b1 the way in pair 0/1, b2 the way in pair 2/3
  typedef struct packed {
    logic b0;
    logic b1;
    logic b2;
  } tree_t;

  localparam int unsigned NWAYS  = 4;
  localparam int unsigned NPAIRS = NWAYS / 2;

  function automatic way_t tree_point(input tree_t t);
    way_t w;
    w[1] = t.b0;
    w[0] = t.b0 ? t.b2 : t.b1;
    return w;
  endfunction
endpackage

// File: rtl/lru4_state_mem.sv
module lru4_state_mem
  import lru4_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_idx,
  output tree_t            rd_bits,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  tree_t            wr_bits
);
  tree_t store [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) store[s] <= '0;
    end else if (wr_en) begin
      store[wr_idx] <= wr_bits;
    end
  end

  assign rd_bits = store[rd_idx];
endmodule

// File: rtl/lru4_next_state.sv
module lru4_next_state
  import lru4_pkg::*;
(
  input  tree_t      cur,
  input  logic       acc_en,
  input  logic       acc_hit,
  input  way_t       hit_way,
  input  logic       acc_inv,
  input  logic [3:0] lock_mask,
  output tree_t      nxt,
  output logic       wr_en
);
  logic all_locked;
  assign all_locked = &lock_mask;

  // Lock state only gates the all-locked miss (no fill happens then)
  assign wr_en = acc_en & (acc_hit | ~all_locked);

  always_comb begin
    nxt = cur;
    if (acc_hit) begin
      // hit: point away from the way; invalidation: point at it
      nxt.b0 = acc_inv ? hit_way[1] : ~hit_way[1];
      if (hit_way[1]) nxt.b2 = acc_inv ? hit_way[0] : ~hit_way[0];
      else            nxt.b1 = acc_inv ? hit_way[0] : ~hit_way[0];
    end else begin
      // miss: step away from the current tree choice
      nxt.b0 = ~cur.b0;
      if (cur.b0) nxt.b2 = ~cur.b2;
      else        nxt.b1 = ~cur.b1;
    end
  end
endmodule

// File: rtl/lru4_victim_pick.sv
module lru4_victim_pick
  import lru4_pkg::*;
(
  input  tree_t      cur,
  input  logic [3:0] lock_mask,
  output way_t       victim_way,
  output logic       victim_ok
);
  logic [NPAIRS-1:0] pair_bit;
  logic [NPAIRS-1:0] pair_full;
  logic [NPAIRS-1:0] pair_low;
  logic              use_pair;

  assign pair_bit = {cur.b2, cur.b1};

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    logic lk_lo, lk_hi;
    assign lk_lo        = lock_mask[2*p];
    assign lk_hi        = lock_mask[2*p+1];
    assign pair_full[p] = lk_lo & lk_hi;
    // sibling takes over when one half is locked
    assign pair_low[p]  = lk_lo ? 1'b1 : (lk_hi ? 1'b0 : pair_bit[p]);
  end

  always_comb begin
    if (pair_full[0])      use_pair = 1'b1;
    else if (pair_full[1]) use_pair = 1'b0;
    else                   use_pair = cur.b0;
  end

  assign victim_ok  = ~&lock_mask;
  assign victim_way = victim_ok ? {use_pair, pair_low[use_pair]} : 2'd0;
endmodule

// File: rtl/lru4_lock_sel.sv
module lru4_lock_sel
  import lru4_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             acc_en,
  input  logic             acc_hit,
  input  logic [1:0]       hit_way,
  input  logic             acc_inv,
  input  logic [3:0]       lock_mask,
  output logic [1:0]       victim_way,
  output logic             victim_ok,
  output logic [2:0]       lru_bits
);
  tree_t cur, nxt;
  logic  wr_en;

  lru4_state_mem #(.SETS(SETS), .SET_W(SET_W)) u_mem (
    .clk(clk), .rst(rst), .rd_idx(set_idx), .rd_bits(cur),
    .wr_en(wr_en), .wr_idx(set_idx), .wr_bits(nxt)
  );

  lru4_next_state u_nxt (
    .cur(cur), .acc_en(acc_en), .acc_hit(acc_hit), .hit_way(hit_way),
    .acc_inv(acc_inv), .lock_mask(lock_mask), .nxt(nxt), .wr_en(wr_en)
  );

  lru4_victim_pick u_pick (
    .cur(cur), .lock_mask(lock_mask),
    .victim_way(victim_way), .victim_ok(victim_ok)
  );

  assign lru_bits = cur;

  // R7: a locked way is never offered as victim
  a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (rst)
    victim_ok |-> !lock_mask[victim_way]);

  // R8: fully locked set has no victim
  a_r8_all_locked: assert property (@(posedge clk) disable iff (rst)
    (&lock_mask) |-> (!victim_ok && victim_way == 2'd0));

  // R4: after a plain hit the tree points away from that way
  a_r4_hit_away: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_hit && !acc_inv) |=>
      (set_idx != $past(set_idx)) ||
      (tree_point(tree_t'(lru_bits)) != $past(hit_way)));

  // R5: after an invalidation the tree points at that way
  a_r5_inv_target: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_hit && acc_inv) |=>
      (set_idx != $past(set_idx)) ||
      (tree_point(tree_t'(lru_bits)) == $past(hit_way)));

  // R3: a miss with a free way flips the pair-select bit
  a_r3_miss_flip: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_hit && !(&lock_mask)) |=>
      (set_idx != $past(set_idx)) || (lru_bits[2] != $past(lru_bits[2])));

  // R9, R10: idle cycles and all-locked misses keep the state
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!acc_en || (!acc_hit && (&lock_mask))) |=>
      (set_idx != $past(set_idx)) || (lru_bits == $past(lru_bits)));
endmodule

// File: tb/sim_lru4_lock_sel.sv
module sim_lru4_lock_sel;
  localparam int SETS  = 64;
  localparam int SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SET_W-1:0] set_idx = '0;
  logic             acc_en = 1'b0, acc_hit = 1'b0, acc_inv = 1'b0;
  logic [1:0]       hit_way = '0;
  logic [3:0]       lock_mask = '0;
  logic [1:0]       victim_way;
  logic             victim_ok;
  logic [2:0]       lru_bits;

  int tests = 0, fails = 0;
  int model [SETS];
  string pend_tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  lru4_lock_sel #(.SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .set_idx(set_idx), .acc_en(acc_en), .acc_hit(acc_hit),
    .hit_way(hit_way), .acc_inv(acc_inv), .lock_mask(lock_mask),
    .victim_way(victim_way), .victim_ok(victim_ok), .lru_bits(lru_bits)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (set %0d lock %b)", req, act, exp, set_idx, lock_mask);
    end
  endtask

  // reference update written straight from the requirement tables
  function automatic int upd(int old, bit hit, int way, bit inv, int lock);
    int r = old;
    if (!hit) begin
      if (lock == 15) return old;                      // R9
      casez (old[2:0])
        3'b00?: r = {2'b11, old[0]};
        3'b01?: r = {2'b10, old[0]};
        3'b1?0: r = {1'b0, old[1], 1'b1};
        default: r = {1'b0, old[1], 1'b0};
      endcase
    end else if (!inv) begin
      case (way)
        0: r = {2'b11, old[0]};
        1: r = {2'b10, old[0]};
        2: r = {1'b0, old[1], 1'b1};
        default: r = {1'b0, old[1], 1'b0};
      endcase
    end else begin
      case (way)
        0: r = {2'b00, old[0]};
        1: r = {2'b01, old[0]};
        2: r = {1'b1, old[1], 1'b0};
        default: r = {1'b1, old[1], 1'b1};
      endcase
    end
    return r;
  endfunction

  // preference list: tree choice, its sibling, other pair's choice, its sibling
  function automatic int pick(int st, int lock);
    int ord [4];
    int b0 = st[2], b1 = st[1], b2 = st[0];
    ord[0] = b0 ? (b2 ? 3 : 2) : (b1 ? 1 : 0);
    ord[1] = ord[0] ^ 1;
    ord[2] = b0 ? (b1 ? 1 : 0) : (b2 ? 3 : 2);
    ord[3] = ord[2] ^ 1;
    foreach (ord[i]) if (!lock[ord[i]]) return ord[i];
    return -1;
  endfunction

  task automatic step(int idx, bit en, bit hit, int way, bit inv, int lock, string tag);
    int v, nl;
    string vt;
    @(negedge clk);
    set_idx = idx[SET_W-1:0]; acc_en = en; acc_hit = hit;
    hit_way = way[1:0]; acc_inv = inv; lock_mask = lock[3:0];
    #2;
    nl = $countones(lock[3:0]);
    vt = (nl >= 3) ? "R8" : (nl > 0) ? "R7" : "R2";
    v  = pick(model[idx], lock);
    chk(vt, victim_ok, (v >= 0) ? 1 : 0);
    chk(vt, victim_way, (v >= 0) ? v : 0);
    chk({pend_tag, "/R11"}, lru_bits, model[idx]);
    @(posedge clk);
    #1;
    if (en) model[idx] = upd(model[idx], hit, way, inv, lock);
    pend_tag = tag;
  endtask

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: every set cleared, victim way 0
    for (int s = 0; s < SETS; s++) step(s, 0, 0, 0, 0, 0, "R1");
    // R4: hits to each way on set 3
    for (int w = 0; w < 4; w++) step(3, 1, 1, w, 0, 0, "R4");
    // R3: a run of misses walks the tree
    for (int k = 0; k < 6; k++) step(5, 1, 0, 0, 0, 0, "R3");
    // R5: invalidations point the tree at the way
    for (int w = 3; w >= 0; w--) step(7, 1, 1, w, 1, 0, "R5");
    // R6: identical traffic with locks set updates the same way
    for (int k = 0; k < 4; k++) step(8, 1, 0, 0, 0, 4'b0101, "R6");
    step(8, 1, 1, 2, 0, 4'b1010, "R6");
    // R7: pair fallback cases
    step(9, 1, 1, 3, 0, 4'b0011, "R7");   // b0=0,b2=0: ways 0/1 locked -> way 2
    step(9, 0, 0, 0, 0, 4'b0011, "R7");
    step(10, 1, 1, 1, 0, 4'b1100, "R7");  // b0=1,b1=0: ways 2/3 locked -> way 0
    step(10, 0, 0, 0, 0, 4'b1100, "R7");
    step(10, 0, 0, 0, 0, 4'b1101, "R8");
    // R9: all-locked miss holds state
    step(11, 1, 1, 2, 0, 0, "R4");
    step(11, 1, 0, 0, 0, 4'b1111, "R9");
    step(11, 0, 0, 0, 0, 4'b1111, "R9");
    // R10: idle strobe with hit inputs and neighbour untouched
    step(12, 0, 1, 0, 0, 0, "R10");
    step(13, 1, 1, 0, 0, 0, "R10");
    step(12, 0, 0, 0, 0, 0, "R10");
    // random traffic on a few sets, all lock patterns
    for (int k = 0; k < 800; k++)
      step($urandom_range(0, 3), $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 15), "R6");
    for (int s = 0; s < 4; s++) step(s, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule